// File: doc/BRIEF.md
# Translation Cache with Global Retention

This block is a small fully associative translation cache for 32-bit linear addresses that are split into 4 KiB pages. Each entry maps a 20-bit virtual page number to a 20-bit physical frame number. An entry also stores a writable bit, a user-access bit and a global flag. A lookup is combinational. The linear address goes in, and in the same cycle the block returns a hit flag, the translated physical address and the permissions of the matching entry.

A page-table walker, which sits outside this block, writes results through the fill port. Fills marked not-present are dropped. A fill whose page number is already cached overwrites that entry in place. A fill with a new page number goes into the slot named by a round-robin pointer.

Three control inputs shape what the cache keeps:
- A base-register reload pulse invalidates entries. While the global-enable level is high, entries flagged global are kept and all others are dropped. While it is low, every entry is dropped.
- A single-page invalidate command removes only the entry for one page number.
- When a reload or an invalidate arrives in the same cycle as a fill, the invalidation is applied first and the fill is written afterwards.

Top module: `tlb_gl_cache`

## Requirements
- R1: A lookup returns hit=1, physical address {pfn, lk_vaddr_i[11:0]} and the stored writable/user bits in the same cycle when a valid entry's tag equals lk_vaddr_i[31:12]. With no match it returns hit=0.
- R2: After reset no entry is valid, so every lookup misses, and the replacement pointer is 0.
- R3: A reload pulse with glob_en_i=0 invalidates every entry.
- R4: A reload pulse with glob_en_i=1 invalidates only the entries whose global flag is 0. Global entries stay valid and keep their mapping.
- R5: A single-page invalidate removes the entry whose tag equals inv_vaddr_i[31:12]. All other entries keep their state.
- R6: A fill with fill_present_i=0 writes nothing and does not move the replacement pointer.
- R7: A fill whose page number is already held by a valid entry overwrites that entry and does not move the pointer.
- R8: A fill with a new page number is written at the pointer slot, and the pointer then advances by one, modulo 8 entries. Once the cache is full, the oldest-filled slot is the one replaced.
- R9: When a reload or an invalidate is asserted in the same cycle as a present fill, the invalidation is applied first, and the filled entry is valid afterwards.
- R10: No more than one valid entry ever matches a given page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_vaddr_i | input | 32 | Lookup linear address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_paddr_o | output | 32 | Translated physical address |
| lk_write_o | output | 1 | Writable bit of the hit entry |
| lk_user_o | output | 1 | User-access bit of the hit entry |
| fill_valid_i | input | 1 | Fill request |
| fill_vpn_i | input | 20 | Fill virtual page number |
| fill_pfn_i | input | 20 | Fill physical frame number |
| fill_present_i | input | 1 | Walked mapping is present |
| fill_write_i | input | 1 | Fill writable bit |
| fill_user_i | input | 1 | Fill user bit |
| fill_global_i | input | 1 | Fill global flag |
| base_reload_i | input | 1 | Base-register reload pulse |
| glob_en_i | input | 1 | Global retention enable |
| inv_valid_i | input | 1 | Single-page invalidate command |
| inv_vaddr_i | input | 32 | Address whose page is invalidated |

## Verification
Any stale valid bit or stale tag is visible at the lookup port in the cycle after the event that should have cleared it. The lookup is combinational, so the very next probe of that page reports a hit that should be a miss, or it returns the old frame. A replacement pointer that drifts stays hidden until the cache wraps. It then shows up as the wrong page missing on the first eviction after eight new fills. For that reason the sequences run past one full wrap before probing. A duplicate tag would show as a corrupted OR of two frames.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W  = 32;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned PFN_W = 20;
  localparam int unsigned PA_W  = PFN_W + OFF_W;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    logic             wr;
    logic             usr;
    logic             glb;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  tlb_ent_t [N-1:0]   ent_i,
  input  logic     [N-1:0]   valid_i,
  input  logic     [VPN_W-1:0] vpn_i,
  output logic     [N-1:0]   match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (ent_i[g].vpn == vpn_i);
  end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == IDX_W'(N-1)) ? '0 : ptr_q + IDX_W'(1);
  end

  assign ptr_o = ptr_q;

  assert_ptr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_q == (($past(ptr_q) == IDX_W'(N-1)) ? '0 : $past(ptr_q) + IDX_W'(1)));
  assert_ptr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q));
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     kill_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  tlb_ent_t         wdata_i,
  output tlb_ent_t [N-1:0] ent_o,
  output logic [N-1:0]     valid_o
);
  tlb_ent_t [N-1:0] ent_q;
  logic     [N-1:0] valid_q;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic sel;
    assign sel = we_i && (widx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        ent_q[g]   <= '0;
      end else begin
        // kill first, write wins
        valid_q[g] <= sel | (valid_q[g] & ~kill_i[g]);
        if (sel) ent_q[g] <= wdata_i;
      end
    end
  end

  assign ent_o   = ent_q;
  assign valid_o = valid_q;

  assert_write_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> valid_q[$past(widx_i)] && ent_q[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/tlb_gl_cache.sv
module tlb_gl_cache
  import tlb_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  output logic              lk_hit_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  output logic              lk_write_o,
  output logic              lk_user_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_present_i,
  input  logic              fill_write_i,
  input  logic              fill_user_i,
  input  logic              fill_global_i,
  input  logic              base_reload_i,
  input  logic              glob_en_i,
  input  logic              inv_valid_i,
  input  logic [VA_W-1:0]   inv_vaddr_i
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  tlb_ent_t [N-1:0] ent;
  logic [N-1:0]     valid_q, glob_vec, lk_match, inv_match, fill_match;
  logic [N-1:0]     kill, valid_kept;
  logic [IDX_W-1:0] ptr, hit_idx, fill_idx;
  logic             fill_we, fill_hit, adv;
  tlb_ent_t         wdata;

  for (genvar g = 0; g < N; g++) begin : g_glb
    assign glob_vec[g] = ent[g].glb;
  end

  tlb_match #(.N(N)) u_lk_match (
    .ent_i(ent), .valid_i(valid_q), .vpn_i(lk_vaddr_i[VA_W-1:OFF_W]), .match_o(lk_match));
  tlb_match #(.N(N)) u_inv_match (
    .ent_i(ent), .valid_i(valid_q), .vpn_i(inv_vaddr_i[VA_W-1:OFF_W]), .match_o(inv_match));

  // invalidations ahead of the fill
  always_comb begin
    kill = '0;
    if (base_reload_i) kill = glob_en_i ? ~glob_vec : '1;
    if (inv_valid_i)   kill = kill | inv_match;
  end
  assign valid_kept = valid_q & ~kill;

  tlb_match #(.N(N)) u_fill_match (
    .ent_i(ent), .valid_i(valid_kept), .vpn_i(fill_vpn_i), .match_o(fill_match));

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) if (fill_match[i]) hit_idx = IDX_W'(i);
  end

  assign fill_we  = fill_valid_i && fill_present_i;
  assign fill_hit = |fill_match;
  assign fill_idx = fill_hit ? hit_idx : ptr;
  assign adv      = fill_we && !fill_hit;

  assign wdata = '{vpn: fill_vpn_i, pfn: fill_pfn_i, wr: fill_write_i,
                   usr: fill_user_i, glb: fill_global_i};

  tlb_rr_ptr #(.N(N)) u_ptr (.clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .ptr_o(ptr));

  tlb_store #(.N(N)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .kill_i(kill), .we_i(fill_we),
    .widx_i(fill_idx), .wdata_i(wdata), .ent_o(ent), .valid_o(valid_q));

  // one-hot OR mux
  always_comb begin
    lk_paddr_o = '0;
    lk_write_o = 1'b0;
    lk_user_o  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) begin
        lk_paddr_o = lk_paddr_o | {ent[i].pfn, lk_vaddr_i[OFF_W-1:0]};
        lk_write_o = lk_write_o | ent[i].wr;
        lk_user_o  = lk_user_o  | ent[i].usr;
      end
    end
  end
  assign lk_hit_o = |lk_match;

  assert_single_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match) && $onehot0(inv_match));
  assert_full_flush_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_reload_i && !glob_en_i && !fill_we) |=> valid_q == '0);
  assert_global_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_reload_i && glob_en_i && !inv_valid_i) |=>
      (($past(valid_q & glob_vec) & ~valid_q) == '0));
  assert_single_inv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && !base_reload_i && !fill_we) |=>
      valid_q == ($past(valid_q) & ~$past(inv_match)));
  assert_no_nonpresent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !fill_present_i && !base_reload_i && !inv_valid_i) |=> $stable(valid_q));
endmodule

// File: tb/tlb_gl_cache_tb.sv
module tlb_gl_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_write, lk_user;
  logic [31:0] lk_paddr;
  logic        f_valid = 0, f_present = 0, f_write = 0, f_user = 0, f_global = 0;
  logic [19:0] f_vpn = '0, f_pfn = '0;
  logic        reload = 0, gen = 0, inv = 0;
  logic [31:0] inv_addr = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [31:0] va;
    logic        hit;
    logic [31:0] pa;
    logic        wr;
    logic        usr;
  } exp_t;
  exp_t  exp_q[$];
  string req_q[$];

  always #4 clk = ~clk;

  tlb_gl_cache u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_vaddr_i(lk_vaddr), .lk_hit_o(lk_hit), .lk_paddr_o(lk_paddr),
    .lk_write_o(lk_write), .lk_user_o(lk_user),
    .fill_valid_i(f_valid), .fill_vpn_i(f_vpn), .fill_pfn_i(f_pfn),
    .fill_present_i(f_present), .fill_write_i(f_write), .fill_user_i(f_user),
    .fill_global_i(f_global), .base_reload_i(reload), .glob_en_i(gen),
    .inv_valid_i(inv), .inv_vaddr_i(inv_addr));

  task automatic look(input logic [31:0] va, input logic hit, input logic [31:0] pa,
                      input logic wr, input logic usr, input string req);
    @(negedge clk);
    lk_vaddr = va;
    exp_q.push_back('{va: va, hit: hit, pa: pa, wr: wr, usr: usr});
    req_q.push_back(req);
  endtask

  task automatic miss(input logic [31:0] va, input string req);
    look(va, 1'b0, '0, 1'b0, 1'b0, req);
  endtask

  // one-cycle control pulse; fill fields apply when fv=1
  task automatic pulse(input logic fv, input logic [19:0] vpn, input logic [19:0] pfn,
                       input logic pres, input logic w, input logic u, input logic g,
                       input logic rl, input logic ge, input logic iv, input logic [31:0] ia);
    @(negedge clk);
    f_valid = fv; f_vpn = vpn; f_pfn = pfn; f_present = pres;
    f_write = w; f_user = u; f_global = g;
    reload = rl; gen = ge; inv = iv; inv_addr = ia;
    @(negedge clk);
    f_valid = 0; reload = 0; inv = 0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic w, input logic u, input logic g);
    pulse(1, vpn, pfn, 1, w, u, g, 0, gen, 0, '0);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        checks++;
        if (lk_hit !== e.hit ||
            (e.hit && (lk_paddr !== e.pa || lk_write !== e.wr || lk_user !== e.usr))) begin
          errors++;
          $display("FAIL %s va=%h actual hit=%b pa=%h w=%b u=%b expected hit=%b pa=%h w=%b u=%b",
                   r, e.va, lk_hit, lk_paddr, lk_write, lk_user, e.hit, e.pa, e.wr, e.usr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    miss(32'h0000_1234, "R2 reset miss");
    rst_n = 1'b1;
    miss(32'h0000_1234, "R2 empty after reset");
    miss(32'h0000_0000, "R2 empty page0");

    fill(20'h00001, 20'h00AAA, 1, 0, 0);          // slot0
    fill(20'hC0000, 20'h00100, 0, 1, 1);          // slot1, global
    look(32'h0000_1234, 1, 32'h00AA_A234, 1, 0, "R1 hit A");
    look(32'hC000_0ABC, 1, 32'h0010_0ABC, 0, 1, "R1 hit B");
    miss(32'h0000_2000, "R1 miss");

    pulse(1, 20'h00003, 20'h00333, 0, 1, 1, 0, 0, 0, 0, '0);
    miss(32'h0000_3000, "R6 non-present not cached");

    fill(20'h00001, 20'h00BBB, 0, 1, 0);          // overwrite slot0
    look(32'h0000_1234, 1, 32'h00BB_B234, 0, 1, "R7 overwrite");
    look(32'hC000_0000, 1, 32'h0010_0000, 0, 1, "R7 neighbour kept");

    pulse(0, '0, '0, 0, 0, 0, 0, 1, 1, 0, '0);    // reload, retain
    miss(32'h0000_1234, "R4 non-global dropped");
    look(32'hC000_0123, 1, 32'h0010_0123, 0, 1, "R4 global kept");

    fill(20'h00001, 20'h00CCC, 1, 1, 0);          // slot2
    pulse(0, '0, '0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_1FFF);
    miss(32'h0000_1000, "R5 page removed");
    look(32'hC000_0FFF, 1, 32'h0010_0FFF, 0, 1, "R5 other kept");

    pulse(0, '0, '0, 0, 0, 0, 0, 1, 0, 0, '0);    // reload, no retain
    miss(32'hC000_0000, "R3 global dropped without enable");

    pulse(1, 20'h00005, 20'h00555, 1, 1, 0, 0, 1, 0, 0, '0);  // slot3
    look(32'h0000_5010, 1, 32'h0055_5010, 1, 0, "R9 fill after reload");
    pulse(1, 20'h00006, 20'h00666, 1, 0, 0, 0, 0, 0, 1, 32'h0000_6000); // slot4
    look(32'h0000_6020, 1, 32'h0066_6020, 0, 0, "R9 fill after invalidate");

    // eight new pages wrap the pointer (5,6,7,0,1,2,3,4)
    for (int i = 0; i < 8; i++) fill(20'h00010 + 20'(i), 20'h00700 + 20'(i), 0, 0, 0);
    for (int i = 0; i < 8; i++)
      look({20'h00010 + 20'(i), 12'h00C}, 1, {20'h00700 + 20'(i), 12'h00C}, 0, 0, "R8 all held");
    miss(32'h0000_5000, "R8 evicted");
    miss(32'h0000_6000, "R8 evicted");
    fill(20'h00018, 20'h00718, 0, 0, 0);          // replaces oldest (page 0x10)
    miss(32'h0001_0000, "R8 oldest replaced");
    look(32'h0001_1000, 1, 32'h0070_1000, 0, 0, "R8 next kept");
    look(32'h0001_8004, 1, 32'h0071_8004, 0, 0, "R8 new present");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule